// File: doc/BRIEF.md
# DC Level Metering Integrator

This block measures a slow DC quantity by integrating a stream of decimated signed samples over a chosen number of sample periods. Eight measurement sources arrive in parallel, each as a signed 19-bit sample. All of them are updated together on a common sample strobe, at roughly 2 kHz. A 4-bit select code picks one source. A signed offset correction is added to the picked sample to cancel sensor and converter offset. The corrected value can then be multiplied by 16 and can be full-wave rectified.

Each conditioned sample is arithmetically shifted right by a programmable amount K before it reaches the accumulator. A long window therefore fits in the 24-bit result. Any overflow that still happens pins the result to signed full scale. At the end of each window the block publishes the result with a one-cycle valid pulse, and the result is held until the next window completes. Software configures the block through a small byte-wide write port.

Top module: `dc_level_integrator`

## Requirements
- R1: Select codes map to source slots as follows: 0100→slot 0, 0101→1, 1001→2, 1010→3, 1011→4, 1101→5, 1110→6, 1111→7. Slot n is `src_samples[n*19 +: 19]`. Any other code makes the picked sample zero.
- R2: The 16-bit signed offset, written as low byte at address 2 and high byte at address 3, is added to the picked sample. The sum is clamped to the signed 19-bit range [-262144, 262143].
- R3: When control bit 1 (address 0) is set, the clamped sum is multiplied by 16. When the bit is clear, the sum passes unscaled.
- R4: When control bit 2 is set, a negative value after the gain stage is replaced by its magnitude. The value -4194304 becomes 4194303. When the bit is clear, the sign is kept.
- R5: Control bits 6:4 give K (0 to 7). Each conditioned sample is arithmetically shifted right by K, rounding toward minus infinity, before it is added to the accumulator.
- R6: The window length is a 16-bit count, low byte at address 4 and high byte at address 5. A value of 0 acts as 1. After the last strobe of a window, `res_valid` is high for exactly one cycle, the cycle after the clock edge that took that strobe, and `res_data` then holds the sum of the shifted samples.
- R7: If a running sum leaves the signed 24-bit range, the window's result is +8388607 or -8388608 according to the direction of the overflow. The result stays there for the rest of that window whatever samples follow. A sum of exactly -8388608 is not an overflow.
- R8: `res_data` keeps its value between result pulses.
- R9: While the meter is enabled, a write that changes K, gain or rectify (address 0), or the select code (address 1), discards the partial window. Writes to the offset or window registers do not.
- R10: While control bit 0 (enable) is clear, strobes are ignored, no result is produced, and the accumulator is empty. The next enable starts a fresh window.
- R11: After reset, `res_data` is 0, `res_valid` is 0, all settings are zero and the meter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| smp_stb | input | 1 | A new set of source samples is present |
| src_samples | input | 152 | Eight signed 19-bit source samples, slot n at bits n*19 upward |
| res_data | output | 24 | Signed integration result |
| res_valid | output | 1 | One-cycle pulse when a new result is published |

## Verification
Every legal select code is tried with all eight slots holding distinct values, so a wrong slot mapping shows as a wrong result, and an illegal code is checked to yield zero. Offset, gain and rectify are each tried with values on both sides of their clamp points. This separates wrapping from clamping and separates a plain negation from a saturated one. Multi-sample windows with mixed-sign samples and K = 3 separate shifting each sample from shifting the final sum. Sequences that overflow positively, land exactly on negative full scale, or overflow and then receive an opposing sample separate sticky saturation from wrap-around and from late recovery. Mid-window writes to the control, offset and enable settings show which writes discard a partial window and which do not.

// File: rtl/dclm_pkg.sv
// Shared definitions for the DC level metering integrator.
// Holds the register addresses, the control field layout and the mapping
// from the 4-bit select code to one of the eight source slots.
package dclm_pkg;

    localparam int NSRC    = 8;
    localparam int SHIFT_W = 3;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_SEL    = 3'd1;
    localparam logic [2:0] A_OFS_LO = 3'd2;
    localparam logic [2:0] A_OFS_HI = 3'd3;
    localparam logic [2:0] A_WIN_LO = 3'd4;
    localparam logic [2:0] A_WIN_HI = 3'd5;

    // Control register: bits 6:4 shift, bit 2 rectify, bit 1 gain, bit 0 enable
    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               rect;
        logic               gain;
        logic               en;
    } ctrl_t;

    // Returns {valid, slot[2:0]} for a select code
    function automatic logic [3:0] src_lookup(input logic [3:0] code);
        case (code)
            4'b0100: return 4'b1000;
            4'b0101: return 4'b1001;
            4'b1001: return 4'b1010;
            4'b1010: return 4'b1011;
            4'b1011: return 4'b1100;
            4'b1101: return 4'b1101;
            4'b1110: return 4'b1110;
            4'b1111: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/dclm_cfg_regs.sv
// Configuration register file for the DC level meter.
// Write-only byte registers: control, select, offset (two bytes) and window
// length (two bytes). It also flags a window restart when an enabled meter
// sees a write that changes its select code or its control fields.
// Assumes REG_W >= 7 so the control fields fit in one register.
module dclm_cfg_regs
    import dclm_pkg::*;
#(
    parameter int REG_W = 8,
    localparam int WIDE_W = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output ctrl_t             ctrl,
    output logic [3:0]        sel_code,
    output logic [WIDE_W-1:0] ofs,
    output logic [WIDE_W-1:0] win_len,
    output logic              restart
);

    ctrl_t             ctrl_q;
    logic [3:0]        sel_q;
    logic [REG_W-1:0]  ofs_lo_q, ofs_hi_q, win_lo_q, win_hi_q;

    // Register writes from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            sel_q    <= '0;
            ofs_lo_q <= '0;
            ofs_hi_q <= '0;
            win_lo_q <= '0;
            win_hi_q <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                A_CTRL:   ctrl_q   <= ctrl_t'({cfg_wdata[6:4], cfg_wdata[2:0]});
                A_SEL:    sel_q    <= cfg_wdata[3:0];
                A_OFS_LO: ofs_lo_q <= cfg_wdata;
                A_OFS_HI: ofs_hi_q <= cfg_wdata;
                A_WIN_LO: win_lo_q <= cfg_wdata;
                A_WIN_HI: win_hi_q <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    // Restart request: an enabled meter sees a changed select or conditioning setting
    always_comb begin
        restart = 1'b0;
        if (cfg_wr && ctrl_q.en) begin
            if (cfg_addr == A_CTRL && cfg_wdata[0] &&
                {cfg_wdata[6:4], cfg_wdata[2:1]} != {ctrl_q.shift, ctrl_q.rect, ctrl_q.gain})
                restart = 1'b1;
            if (cfg_addr == A_SEL && cfg_wdata[3:0] != sel_q)
                restart = 1'b1;
        end
    end

    assign ctrl     = ctrl_q;
    assign sel_code = sel_q;
    assign ofs      = {ofs_hi_q, ofs_lo_q};
    assign win_len  = {win_hi_q, win_lo_q};

endmodule

// File: rtl/dclm_condition.sv
// Sample conditioning path, purely combinational.
// Picks one source slot, adds the signed offset with clamping, applies the
// optional x(2**GAIN_SH) gain, the optional saturating rectifier and the
// arithmetic right shift K. Assumes OFS_W <= SMP_W.
module dclm_condition
    import dclm_pkg::*;
#(
    parameter int SMP_W   = 19,
    parameter int OFS_W   = 16,
    parameter int GAIN_SH = 4,
    localparam int OUT_W  = SMP_W + GAIN_SH
) (
    input  logic [NSRC*SMP_W-1:0]   src_flat,
    input  logic [3:0]              sel_code,
    input  logic [OFS_W-1:0]        ofs,
    input  logic                    gain_en,
    input  logic                    rect_en,
    input  logic [SHIFT_W-1:0]      shift,
    output logic signed [OUT_W-1:0] cond_out
);

    localparam int SUM_W = SMP_W + 1;
    localparam logic signed [SMP_W-1:0] SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic signed [SMP_W-1:0] SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [SMP_W-1:0] src_arr [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_unpack
        assign src_arr[g] = src_flat[g*SMP_W +: SMP_W];
    end

    logic [3:0]              lookup;
    logic signed [SMP_W-1:0] picked;
    logic signed [SUM_W-1:0] sum;
    logic signed [SMP_W-1:0] clamped;
    logic signed [OUT_W-1:0] gained;
    logic signed [OUT_W-1:0] rectified;

    // Source selection; an unknown code yields zero
    always_comb begin
        lookup = src_lookup(sel_code);
        picked = lookup[3] ? src_arr[lookup[2:0]] : '0;
    end

    // Offset summation with clamping to the sample range
    always_comb begin
        sum = {picked[SMP_W-1], picked} + {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        if (sum[SUM_W-1] != sum[SUM_W-2])
            clamped = sum[SUM_W-1] ? SMP_MIN : SMP_MAX;
        else
            clamped = sum[SMP_W-1:0];
    end

    // Gain, rectifier and pre-integration shift
    always_comb begin
        gained = gain_en ? {clamped, {GAIN_SH{1'b0}}}
                         : {{GAIN_SH{clamped[SMP_W-1]}}, clamped};
        rectified = gained;
        if (rect_en && gained[OUT_W-1])
            rectified = (gained == OUT_MIN) ? OUT_MAX : -gained;
        cond_out = rectified >>> shift;
    end

endmodule

// File: rtl/dclm_integrator.sv
// Windowed integrator with sticky saturation.
// Adds one conditioned sample per accepted strobe. After win_len samples
// (0 acts as 1) it publishes the sum with a one-cycle valid pulse and clears.
// An overflow pins the running sum to full scale for the rest of the window.
// Disable or restart clears the window. Assumes IN_W < RES_W.
module dclm_integrator #(
    parameter int IN_W  = 23,
    parameter int RES_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    restart,
    input  logic                    stb,
    input  logic signed [IN_W-1:0]  x,
    input  logic [CNT_W-1:0]        win_len,
    output logic signed [RES_W-1:0] res_data,
    output logic                    res_valid
);

    localparam int ACC_W = RES_W + 1;
    localparam logic signed [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic signed [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

    logic signed [RES_W-1:0] acc;
    logic [CNT_W-1:0]        cnt;
    logic                    ovf_q;

    logic                    take;
    logic signed [ACC_W-1:0] wide;
    logic                    ovf_now;
    logic signed [RES_W-1:0] step;
    logic [CNT_W:0]          cnt_inc;
    logic                    last;

    // Next accumulator value with saturation and end-of-window detection
    always_comb begin
        take    = stb && en && !restart;
        wide    = {acc[RES_W-1], acc} + {{(ACC_W-IN_W){x[IN_W-1]}}, x};
        ovf_now = wide[ACC_W-1] != wide[ACC_W-2];
        if (ovf_q)
            step = acc;
        else if (ovf_now)
            step = wide[ACC_W-1] ? RES_MIN : RES_MAX;
        else
            step = wide[RES_W-1:0];
        cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        last    = cnt_inc >= {1'b0, win_len};
    end

    // Accumulation, window counting and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            cnt       <= '0;
            ovf_q     <= 1'b0;
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (!en || restart) begin
                acc   <= '0;
                cnt   <= '0;
                ovf_q <= 1'b0;
            end else if (stb) begin
                if (last) begin
                    res_data  <= step;
                    res_valid <= 1'b1;
                    acc       <= '0;
                    cnt       <= '0;
                    ovf_q     <= 1'b0;
                end else begin
                    acc   <= step;
                    cnt   <= cnt + 1'b1;
                    ovf_q <= ovf_q | ovf_now;
                end
            end
        end
    end

    // R6: a result pulse only follows an accepted strobe
    assert_valid_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(take));

    // R8: the published result does not move between pulses
    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    // R10: a disabled meter keeps an empty window
    assert_disabled_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc == '0 && cnt == '0));

    // R9: a restart discards the partial window
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc == '0 && cnt == '0 && !ovf_q));

    // R7: after an overflow the running sum sits at full scale
    assert_sat_fullscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (acc == RES_MAX || acc == RES_MIN));

endmodule

// File: rtl/dc_level_integrator.sv
// Top level of the DC level meter.
// Ties the configuration registers, the conditioning path and the windowed
// integrator together. Source samples are sampled on the clock edge where
// smp_stb is high; settings written on an edge apply from the next edge.
module dc_level_integrator
    import dclm_pkg::*;
#(
    parameter int SMP_W   = 19,
    parameter int REG_W   = 8,
    parameter int GAIN_SH = 4,
    parameter int RES_W   = 24,
    localparam int WIDE_W = 2 * REG_W,
    localparam int COND_W = SMP_W + GAIN_SH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [2:0]              cfg_addr,
    input  logic [REG_W-1:0]        cfg_wdata,
    input  logic                    smp_stb,
    input  logic [NSRC*SMP_W-1:0]   src_samples,
    output logic signed [RES_W-1:0] res_data,
    output logic                    res_valid
);

    ctrl_t                    ctrl;
    logic [3:0]               sel_code;
    logic [WIDE_W-1:0]        ofs;
    logic [WIDE_W-1:0]        win_len;
    logic                     restart;
    logic signed [COND_W-1:0] cond_val;

    dclm_cfg_regs #(.REG_W(REG_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .sel_code  (sel_code),
        .ofs       (ofs),
        .win_len   (win_len),
        .restart   (restart)
    );

    dclm_condition #(.SMP_W(SMP_W), .OFS_W(WIDE_W), .GAIN_SH(GAIN_SH)) i_cond (
        .src_flat (src_samples),
        .sel_code (sel_code),
        .ofs      (ofs),
        .gain_en  (ctrl.gain),
        .rect_en  (ctrl.rect),
        .shift    (ctrl.shift),
        .cond_out (cond_val)
    );

    dclm_integrator #(.IN_W(COND_W), .RES_W(RES_W), .CNT_W(WIDE_W)) i_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .restart   (restart),
        .stb       (smp_stb),
        .x         (cond_val),
        .win_len   (win_len),
        .res_data  (res_data),
        .res_valid (res_valid)
    );

    // R4: with the rectifier on, the conditioned sample is never negative
    assert_rect_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.rect |-> !cond_val[COND_W-1]);

endmodule

// File: tb/test_dc_level_integrator.sv
module test_dc_level_integrator;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              smp_stb = 1'b0;
    logic [8*19-1:0]   src_flat;
    logic signed [23:0] res_data;
    logic              res_valid;

    logic signed [18:0] srcs [8];
    int total = 0;
    int bad = 0;

    // model state
    int     cur_idx;
    longint cur_ofs;
    bit     cur_gain, cur_rect;
    int     cur_k;
    longint exp_acc;
    bit     exp_ovf;

    localparam logic [3:0] CODES [8] = '{4'b0100, 4'b0101, 4'b1001, 4'b1010,
                                         4'b1011, 4'b1101, 4'b1110, 4'b1111};

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) src_flat[i*19 +: 19] = srcs[i];
    end

    dc_level_integrator i_dc_level_integrator (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_stb(smp_stb), .src_samples(src_flat),
        .res_data(res_data), .res_valid(res_valid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint s);
        longint v;
        v = s + cur_ofs;
        if (v > 262143) v = 262143;
        if (v < -262144) v = -262144;
        if (cur_gain) v = v * 16;
        if (cur_rect && v < 0) v = (v == -4194304) ? 4194303 : -v;
        v = v >>> cur_k;
        return v;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic push(input longint v);
        longint x;
        if (cur_idx >= 0) srcs[cur_idx] = 19'(v);
        x = (cur_idx >= 0) ? model(v) : model(0);
        if (!exp_ovf) begin
            exp_acc += x;
            if (exp_acc > 8388607) begin exp_acc = 8388607; exp_ovf = 1; end
            else if (exp_acc < -8388608) begin exp_acc = -8388608; exp_ovf = 1; end
        end
        pulse();
    endtask

    task automatic expect_result(input string req);
        check({req, " valid"}, longint'(res_valid), 1);
        check({req, " data"}, longint'(res_data), exp_acc);
        exp_acc = 0; exp_ovf = 0;
    endtask

    task automatic expect_none(input string req);
        check({req, " no valid"}, longint'(res_valid), 0);
    endtask

    task automatic setup(input logic [3:0] code, input int idx, input int ofs,
                         input int win, input bit g, input bit r, input int k);
        wr(3'd0, 8'h00);
        wr(3'd1, {4'h0, code});
        wr(3'd2, ofs[7:0]);
        wr(3'd3, ofs[15:8]);
        wr(3'd4, win[7:0]);
        wr(3'd5, win[15:8]);
        wr(3'd0, {1'b0, k[2:0], 1'b0, r, g, 1'b1});
        cur_idx = idx; cur_ofs = ofs; cur_gain = g; cur_rect = r; cur_k = k;
        exp_acc = 0; exp_ovf = 0;
    endtask

    task automatic t_reset();
        check("R11 reset data", longint'(res_data), 0);
        check("R11 reset valid", longint'(res_valid), 0);
        pulse();
        check("R11 disabled after reset", longint'(res_valid), 0);
    endtask

    task automatic t_select();
        for (int i = 0; i < 8; i++) srcs[i] = 19'(1000 * (i + 1) + 7 * i);
        for (int i = 0; i < 8; i++) begin
            setup(CODES[i], i, 0, 1, 0, 0, 0);
            pulse();
            check("R1 slot data", longint'(res_data), 1000 * (i + 1) + 7 * i);
        end
        setup(4'b0000, -1, 0, 1, 0, 0, 0);
        push(0);
        expect_result("R1 invalid code");
    endtask

    task automatic t_offset();
        setup(4'b0100, 0, 4660, 1, 0, 0, 0);
        push(-100); expect_result("R2 offset add");
        setup(4'b0100, 0, -32768, 1, 0, 0, 0);
        push(-262000); expect_result("R2 clamp low");
        check("R2 clamp low value", longint'(res_data), -262144);
        setup(4'b0100, 0, 32767, 1, 0, 0, 0);
        push(262000); expect_result("R2 clamp high");
    endtask

    task automatic t_gain_rect();
        setup(4'b0101, 1, 5, 1, 1, 0, 0);
        push(1000); expect_result("R3 gain16");
        check("R3 gain16 value", longint'(res_data), 16080);
        setup(4'b0101, 1, 0, 1, 0, 1, 0);
        push(-5000); expect_result("R4 rectify");
        setup(4'b0101, 1, 0, 1, 0, 0, 0);
        push(-5000); expect_result("R4 rectifier off");
        setup(4'b0101, 1, 0, 1, 1, 1, 0);
        push(-262144); expect_result("R4 rectify full scale");
        check("R4 rectify full scale value", longint'(res_data), 4194303);
    endtask

    task automatic t_shift_window();
        setup(4'b1001, 2, 0, 4, 0, 0, 3);
        push(7);   expect_none("R6 window 1/4");
        push(-9);  expect_none("R6 window 2/4");
        push(100); expect_none("R6 window 3/4");
        push(8);   expect_result("R5 shift per sample");
        check("R5 shift sum value", longint'(res_data), 11);
        @(negedge clk);
        check("R6 single pulse", longint'(res_valid), 0);
        repeat (5) @(negedge clk);
        check("R8 held", longint'(res_data), 11);
        setup(4'b1001, 2, 0, 1, 1, 0, 7);
        push(262143); expect_result("R5 shift seven");
        setup(4'b1010, 3, 0, 0, 0, 0, 0);
        push(42); expect_result("R6 window zero acts as one");
    endtask

    task automatic t_overflow();
        setup(4'b1011, 4, 32767, 3, 1, 0, 0);
        push(262143); expect_none("R7 ovf 1");
        push(262143); expect_none("R7 ovf 2");
        push(262143); expect_result("R7 positive overflow");
        check("R7 positive full scale", longint'(res_data), 8388607);
        setup(4'b1011, 4, 0, 2, 1, 0, 0);
        push(-262144); push(-262144); expect_result("R7 exact negative full scale");
        setup(4'b1011, 4, 0, 3, 1, 0, 0);
        push(-262144); push(-262144); push(-262144);
        expect_result("R7 negative overflow");
        setup(4'b1011, 4, 32767, 4, 1, 0, 0);
        push(262143); push(262143); push(262143);
        cur_ofs = 32767; push(-262144);
        expect_result("R7 sticky saturation");
        check("R7 sticky value", longint'(res_data), 8388607);
    endtask

    task automatic t_restart();
        setup(4'b1101, 5, 0, 3, 0, 0, 0);
        push(10); push(20); expect_none("R9 partial");
        wr(3'd0, 8'h05);
        cur_rect = 1; exp_acc = 0; exp_ovf = 0;
        push(1); push(2); expect_none("R9 after restart");
        push(3); expect_result("R9 ctrl change restarts");
        setup(4'b1101, 5, 0, 2, 0, 0, 0);
        push(5);
        wr(3'd2, 8'h01);
        cur_ofs = 1;
        push(5); expect_result("R9 offset write keeps window");
        check("R9 offset window value", longint'(res_data), 11);
    endtask

    task automatic t_disable();
        setup(4'b1110, 6, 0, 2, 0, 0, 0);
        push(7);
        wr(3'd0, 8'h00);
        srcs[6] = 19'(100);
        pulse();
        check("R10 disabled no valid", longint'(res_valid), 0);
        pulse();
        check("R10 disabled no valid 2", longint'(res_valid), 0);
        check("R8 held while disabled", longint'(res_data), 11);
        wr(3'd0, 8'h01);
        exp_acc = 0; exp_ovf = 0;
        push(3); expect_none("R10 fresh window");
        push(4); expect_result("R10 fresh window result");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) srcs[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_offset();
        t_gain_rect();
        t_shift_window();
        t_overflow();
        t_restart();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule